// File: doc/BRIEF.md
# Receive Buffer and Line Status Flags

This block sits behind the receive shift register of a 16550-style UART. Each time the shift register finishes a character it presents the data byte, a parity-error flag and a missing-stop-bit flag for one cycle. The block stores the character and gives the CPU two read views. One is the oldest unread character. The other is an eight-bit line status byte that carries data-ready, overrun, parity-error and framing-error bits.

Two storage modes are supported. In queued mode a 16-entry queue holds the characters, and the error flags stay attached to their own character. Those flags appear in the status byte only when that character becomes the oldest one. In single mode there is a single holding register, and a new character replaces an unread one. A change of mode empties the storage. Reading the status byte clears its sticky error bits. Reading the receive buffer removes the oldest character.

Top module: `rxls_line_status`

## Requirements
- R1: After reset the status byte `lsr` is 0x00 and `rbr_data` is 0.
- R2: Status bit 0 (data ready) is 1 from the cycle after a character is stored, and it stays 1 until the cycle after the last stored character is read with `rd_rbr`.
- R3: In queued mode (`fifo_en`=1) up to DEPTH (16) characters are held in arrival order. `rbr_data` shows the oldest character, or 0 when storage is empty. A cycle with `rd_rbr` high removes the oldest character.
- R4: In queued mode, a character that arrives when the queue is full and no read happens in the same cycle is discarded. The stored characters are kept and status bit 1 (overrun) is set. A read in the same cycle makes room, so the character is accepted.
- R5: In single mode (`fifo_en`=0) at most one character is held. A character that arrives while one is unread, with no read in the same cycle, replaces it and sets overrun.
- R6: Overrun is set in the cycle after an overrun event. It stays set until a cycle with `rd_lsr` high and no new overrun event, and it clears in the cycle after that read.
- R7: Status bit 2 (parity error) and bit 3 (framing error) show the flags of the oldest character, loaded when that character becomes the oldest. A `rd_lsr` clears them. If a new character becomes the oldest in the same cycle as the read, its flags are shown. Both bits are 0 whenever storage is empty.
- R8: Status bits 7 to 4 always read 0.
- R9: A cycle in which `fifo_en` differs from the mode in use empties the storage, drops any character that arrives in that cycle, and clears bits 2 and 3. Overrun is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = queued mode, 0 = single holding register |
| rx_valid | input | 1 | One-cycle strobe: a character has completed |
| rx_data | input | DATA_W | Completed character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Missing stop bit flag of the character |
| rd_rbr | input | 1 | CPU read of the receive buffer (removes oldest) |
| rd_lsr | input | 1 | CPU read of the status byte (clears sticky bits) |
| rbr_data | output | DATA_W | Oldest stored character, 0 when empty |
| lsr | output | 8 | {4'b0, framing err, parity err, overrun, data ready} |

## Verification
A wrong pointer or count shows up on `rbr_data` at the next read as a character out of order or a repeated one. When the count is wrong, data ready falls too early or too late. A misplaced error flag shows up in bits 2 and 3 one cycle after the tagged character reaches the head, so the bench compares every output field against an arithmetic model on every cycle. Mode switches, full-queue arrivals and reads that coincide with arrivals are driven directly, because a fault in those cases is visible only in that cycle.

// File: rtl/rxls_pkg.sv
package rxls_pkg;
  typedef struct packed {
    logic ferr;
    logic perr;
  } rx_err_t;

  localparam int unsigned LSR_W = 8;
endpackage

// File: rtl/rxls_store.sv
module rxls_store
  import rxls_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  rx_err_t           rx_err,
  input  logic              rd_rbr,
  output logic [DATA_W-1:0] head_data,
  output logic              cnt_nz,
  output logic              ovr_evt,
  output logic              head_load,
  output rx_err_t           head_next_err
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic              mode_q, mode_d;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CW-1:0]     cnt_q, cnt_d, cnt_after_pop;
  logic [DATA_W-1:0] mem_d [DEPTH];
  rx_err_t           mem_e [DEPTH];

  logic flush, pop, room, accept, overwrite, we;
  logic [AW-1:0] waddr;

  // next-state
  always_comb begin
    flush         = (fifo_en != mode_q);
    pop           = rd_rbr & (cnt_q != '0) & ~flush;
    cnt_after_pop = cnt_q - CW'(pop);
    room          = mode_q ? (cnt_after_pop != CW'(DEPTH)) : (cnt_after_pop == '0);
    accept        = rx_valid & ~flush & room;
    ovr_evt       = rx_valid & ~flush & ~room;
    overwrite     = ovr_evt & ~mode_q;
    we            = accept | overwrite;
    waddr         = overwrite ? rd_ptr_q : wr_ptr_q;

    mode_d   = fifo_en;
    cnt_d    = flush ? '0 : cnt_after_pop + CW'(accept);
    rd_ptr_d = flush ? '0 : (pop ? ptr_inc(rd_ptr_q) : rd_ptr_q);
    wr_ptr_d = flush ? '0 : (accept ? ptr_inc(wr_ptr_q) : wr_ptr_q);

    head_load = flush | pop | overwrite | (accept & (cnt_after_pop == '0));
    if (flush) begin
      head_next_err = '0;
    end else if (overwrite || (accept && cnt_after_pop == '0)) begin
      head_next_err = rx_err;
    end else if (pop && cnt_after_pop != '0) begin
      head_next_err = mem_e[ptr_inc(rd_ptr_q)];
    end else begin
      head_next_err = '0;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
    end else begin
      mode_q   <= mode_d;
      cnt_q    <= cnt_d;
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
    end
  end

  // storage array, write-enabled, no reset
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && waddr == AW'(i)) begin
        mem_d[i] <= rx_data;
        mem_e[i] <= rx_err;
      end
    end
  end

  assign cnt_nz    = (cnt_q != '0);
  assign head_data = cnt_nz ? mem_d[rd_ptr_q] : '0;

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r5_single_holding: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> cnt_q <= CW'(1));
  a_r4_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && fifo_en && rx_valid && !rd_rbr && cnt_q == CW'(DEPTH))
      |=> (cnt_q == CW'(DEPTH) && $stable(wr_ptr_q) && $stable(rd_ptr_q)));
  a_r2_ready_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cnt_nz);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !cnt_nz);
endmodule

// File: rtl/rxls_flags.sv
module rxls_flags
  import rxls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_lsr,
  input  logic             ovr_evt,
  input  logic             head_load,
  input  rx_err_t          head_next_err,
  input  logic             cnt_nz,
  output logic [LSR_W-1:0] lsr
);
  logic    oe_q, oe_d;
  rx_err_t shown_q, shown_d;

  always_comb begin
    oe_d = ovr_evt ? 1'b1 : (rd_lsr ? 1'b0 : oe_q);
    if (head_load)   shown_d = head_next_err;
    else if (rd_lsr) shown_d = '0;
    else             shown_d = shown_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      shown_q <= '0;
    end else begin
      oe_q    <= oe_d;
      shown_q <= shown_d;
    end
  end

  assign lsr = {4'b0000, shown_q.ferr, shown_q.perr, oe_q, cnt_nz};

  a_r6_oe_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> lsr[1]);
  a_r6_oe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !ovr_evt) |=> !lsr[1]);
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !head_load) |=> (lsr[3:2] == 2'b00));
  a_r7_no_err_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] |-> (lsr[3:2] == 2'b00));
endmodule

// File: rtl/rxls_line_status.sv
module rxls_line_status
  import rxls_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rd_rbr,
  input  logic              rd_lsr,
  output logic [DATA_W-1:0] rbr_data,
  output logic [7:0]        lsr
);
  rx_err_t rx_err, head_next_err;
  logic    cnt_nz, ovr_evt, head_load;

  assign rx_err = '{ferr: rx_ferr, perr: rx_perr};

  rxls_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en      (fifo_en),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_err       (rx_err),
    .rd_rbr       (rd_rbr),
    .head_data    (rbr_data),
    .cnt_nz       (cnt_nz),
    .ovr_evt      (ovr_evt),
    .head_load    (head_load),
    .head_next_err(head_next_err)
  );

  rxls_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_lsr       (rd_lsr),
    .ovr_evt      (ovr_evt),
    .head_load    (head_load),
    .head_next_err(head_next_err),
    .cnt_nz       (cnt_nz),
    .lsr          (lsr)
  );

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lsr |-> (lsr[7:4] == 4'h0));
endmodule

// File: tb/rxls_line_status_bench.sv
`timescale 1ns/1ps
module rxls_line_status_bench;
  localparam int DEPTH = 16;
  localparam int MAX_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0, rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
  logic       rd_rbr = 1'b0, rd_lsr = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [7:0] rbr_data, lsr;

  always #5 clk = ~clk;

  rxls_line_status #(.DEPTH(DEPTH), .DATA_W(8)) u_rxls_line_status (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rd_rbr(rd_rbr), .rd_lsr(rd_lsr), .rbr_data(rbr_data), .lsr(lsr)
  );

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  // model state: entry = {ferr, perr, data}
  logic [9:0] q[$];
  bit m_oe, m_pe, m_fe, m_mode;
  string tag = "R1";

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R2", "data ready", int'(lsr[0]), int'(q.size() != 0));
    check("R6", "overrun", int'(lsr[1]), int'(m_oe));
    check("R7", "parity err", int'(lsr[2]), int'(m_pe));
    check("R7", "framing err", int'(lsr[3]), int'(m_fe));
    check("R8", "upper bits", int'(lsr[7:4]), 0);
    check(tag, "rbr_data", int'(rbr_data), (q.size() != 0) ? int'(q[0][7:0]) : 0);
  endtask

  task automatic model_step(bit fe_in, bit v, bit [7:0] d, bit pe, bit fr, bit rr, bit rl);
    bit flush, pop, room, ovr, load;
    int n_after;
    flush = (fe_in != m_mode);
    if (flush) begin
      q.delete();
      m_pe = 1'b0; m_fe = 1'b0;
      m_mode = fe_in;
      if (rl) m_oe = 1'b0;
      return;
    end
    pop = rr && (q.size() != 0);
    n_after = q.size() - int'(pop);
    room = m_mode ? (n_after < DEPTH) : (n_after == 0);
    load = 1'b0; ovr = 1'b0;
    if (pop) begin void'(q.pop_front()); load = 1'b1; end
    if (v) begin
      if (room) begin
        q.push_back({fr, pe, d});
        if (n_after == 0) load = 1'b1;
      end else begin
        ovr = 1'b1;
        if (!m_mode) begin q[0] = {fr, pe, d}; load = 1'b1; end
      end
    end
    if (ovr) m_oe = 1'b1; else if (rl) m_oe = 1'b0;
    if (load) begin
      if (q.size() != 0) begin m_fe = q[0][9]; m_pe = q[0][8]; end
      else begin m_fe = 1'b0; m_pe = 1'b0; end
    end else if (rl) begin
      m_fe = 1'b0; m_pe = 1'b0;
    end
  endtask

  // one cycle: called at negedge; drives, advances model, checks at next negedge
  task automatic cyc(bit fe_in, bit v, bit [7:0] d, bit pe, bit fr, bit rr, bit rl);
    fifo_en = fe_in; rx_valid = v; rx_data = d; rx_perr = pe; rx_ferr = fr;
    rd_rbr = rr; rd_lsr = rl;
    model_step(fe_in, v, d, pe, fr, rr, rl);
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(MAX_CYC * 10);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_oe = 0; m_pe = 0; m_fe = 0; m_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "lsr after reset", int'(lsr), 0);
    check("R1", "rbr after reset", int'(rbr_data), 0);

    // R9: switch into queued mode (flush cycle drops arrival)
    tag = "R9";
    cyc(1, 1, 8'hAA, 1, 0, 0, 0);
    check("R9", "dropped on switch", int'(lsr[0]), 0);

    // R4: fill to 16 plus four overruns, errors on selected characters
    tag = "R4";
    for (int i = 0; i < DEPTH + 4; i++)
      cyc(1, 1, 8'(i * 7 + 3), bit'(i % 3 == 0), bit'(i % 5 == 1), 0, 0);
    check("R4", "overrun flagged", int'(lsr[1]), 1);
    // arrival with simultaneous read when full is accepted
    cyc(1, 1, 8'hE5, 1, 1, 1, 0);
    // R6: read status while an overrun happens keeps overrun
    cyc(1, 1, 8'h11, 0, 0, 0, 1);
    check("R6", "overrun kept on coincident read", int'(lsr[1]), 1);
    cyc(1, 0, 0, 0, 0, 0, 1);
    check("R6", "overrun cleared", int'(lsr[1]), 0);

    // R3: drain in order, mixing status reads with head changes
    tag = "R3";
    for (int i = 0; i < DEPTH + 2; i++)
      cyc(1, 0, 0, 0, 0, 1, bit'(i % 2));
    check("R2", "empty after drain", int'(lsr[0]), 0);

    // R5: single mode
    tag = "R9";
    cyc(0, 1, 8'h55, 0, 0, 0, 0);
    tag = "R5";
    cyc(0, 1, 8'h21, 1, 0, 0, 0);
    cyc(0, 1, 8'h42, 0, 1, 0, 0);
    check("R5", "replaced char", int'(rbr_data), 8'h42);
    check("R5", "overrun in single", int'(lsr[1]), 1);
    cyc(0, 1, 8'h63, 1, 1, 1, 1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    // R9: switch with data present
    cyc(0, 1, 8'h70, 1, 0, 0, 0);
    tag = "R9";
    cyc(1, 1, 8'h71, 0, 0, 0, 0);
    check("R9", "flushed", int'(lsr[0]), 0);

    // R7: sweep of all flag pairs through the head with status reads
    tag = "R7";
    for (int f = 0; f < 4; f++)
      for (int r = 0; r < 4; r++) begin
        cyc(1, 1, 8'(f * 16 + r), bit'(f & 1), bit'(f >> 1), 0, 0);
        cyc(1, 1, 8'(r * 16 + f), bit'(r & 1), bit'(r >> 1), 0, bit'(r == 2));
        cyc(1, 0, 0, 0, 0, 1, bit'(r & 1));
        cyc(1, 0, 0, 0, 0, 1, bit'(r >> 1));
      end

    // mixed sweep over both modes
    tag = "R3";
    for (int n = 0; n < 6000; n++) begin
      bit md;
      int ph;
      ph = n / 500;
      md = (ph % 4 != 3);
      tag = md ? "R3" : "R5";
      cyc(md, bit'($urandom_range(0, 99) < 40 + (ph % 3) * 20),
          8'($urandom), bit'($urandom_range(0, 3) == 0),
          bit'($urandom_range(0, 3) == 0),
          bit'($urandom_range(0, 99) < 50 - (ph % 3) * 15),
          bit'($urandom_range(0, 5) == 0));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule